// File: doc/BRIEF.md
# Prefix Immediate Extension Unit

This unit builds full 16-bit operands for a processor in which every instruction, including the prefix instruction, occupies one 16-bit word. A prefix instruction carries the upper ten bits of a long constant. The unit stores those bits, already shifted into place, in a dedicated register and marks them as pending. The next ordinary instruction then ORs its own short unsigned field into that register value. When no prefix is pending, the short field is only zero-extended. The field is 5 bits for general-register offsets, 6 bits for the mid format, and 8 bits for stack-relative offsets.

Instructions arrive on a valid/ready stream as they retire, and the formed operand leaves on a second valid/ready stream. A prefix produces no output. It is accepted at once, whatever the output side is doing. An ordinary instruction is accepted only in a cycle where the consumer is ready, and `in_ready` follows `out_ready` for it. Nothing is buffered, so the output is combinational from the current input and the stored prefix state. A flush input cancels a pending prefix when the pipeline redirects. While a prefix is pending, the unit withholds interrupt acceptance, so that an interrupt cannot separate a prefix from the instruction it extends.

Top module: `pfx_imm_unit`

## Requirements
- R1: After reset no prefix is pending, `irq_allow` is 1, and `out_imm` for an ordinary instruction carries no upper bits.
- R2: With no prefix pending, `out_imm` is the zero-extended low part of `in_field`. The part is bits 4:0 for `in_wcls`=0, bits 5:0 for `in_wcls`=1, and bits 7:0 for `in_wcls`=2 or 3.
- R3: An accepted prefix (`in_is_pfx`=1) stores `in_field` shifted left by 6 bits. It makes the prefix pending from the next cycle. `out_valid` stays 0 for it, and `in_ready` is 1 for it regardless of `out_ready`.
- R4: While a prefix is pending, `out_imm` is the stored value ORed with the zero-extended field chosen by `in_wcls`. The fields overlap in bits 7:6 for the 8-bit class. Prefix 6 followed by a 6-bit field of 16 gives 400.
- R5: Prefixes do not accumulate: each accepted prefix replaces the stored value, so only the last of a run applies.
- R6: The pending flag clears after the next accepted ordinary instruction. An ordinary instruction held by `out_ready`=0 and idle cycles leave the flag and the stored value untouched.
- R7: `flush` clears the pending flag at the next edge. It also wins over a prefix accepted in the same cycle.
- R8: `irq_allow` is 0 exactly while a prefix is pending, and `irq_take` equals `irq_req` AND `irq_allow`.
- R9: For an ordinary instruction, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline redirect; drops a pending prefix |
| in_valid | input | 1 | Retiring instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_is_pfx | input | 1 | Instruction is a prefix |
| in_wcls | input | 2 | Short-field width class |
| in_field | input | 10 | Immediate field (prefix uses all 10 bits) |
| out_valid | output | 1 | Operand present |
| out_ready | input | 1 | Consumer takes operand |
| out_imm | output | 16 | Extended operand |
| irq_req | input | 1 | Interrupt request |
| irq_allow | output | 1 | Interrupt may be accepted now |
| irq_take | output | 1 | Interrupt accepted this cycle |

## Verification
The operand is due in the same cycle as its input, and it reflects prefix state written at the previous edge. A prefix accepted at one edge affects `out_imm`, `irq_allow` and `irq_take` from the following cycle, and a flush or an accepted ordinary instruction clears that state at the same edge. The bench drives inputs just after a rising edge and compares every port at the falling edge of that same cycle. It updates its own prefix model only after the next rising edge has passed, so each expectation lines up with the register delay.

// File: rtl/pfxu_pkg.sv
package pfxu_pkg;
  typedef enum logic [1:0] {
    WC_GEN = 2'd0,
    WC_MID = 2'd1,
    WC_SP  = 2'd2,
    WC_SPX = 2'd3
  } wcls_t;
endpackage

// File: rtl/pfx_latch.sv
module pfx_latch #(
  parameter int IMM_W = 16,
  parameter int SHIFT = 6,
  localparam int PFX_W = IMM_W - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic             use_op,
  input  logic [PFX_W-1:0] ld_field,
  output logic             pend,
  output logic [IMM_W-1:0] preg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      preg <= '0;
    end else begin
      if (flush)       pend <= 1'b0;
      else if (load)   pend <= 1'b1;
      else if (use_op) pend <= 1'b0;
      if (load && !flush) preg <= {ld_field, {SHIFT{1'b0}}};
    end
  end

  AST_PFX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (pend && preg[SHIFT-1:0] == '0)); // R3
  AST_PFX_OVERWRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (preg[IMM_W-1:SHIFT] == $past(ld_field))); // R5
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend); // R7
  AST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (use_op && !load) |=> !pend); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !use_op && !flush) |=> ($stable(pend) && $stable(preg))); // R6
endmodule

// File: rtl/imm_merge.sv
module imm_merge
  import pfxu_pkg::*;
#(
  parameter int IMM_W = 16,
  parameter int SHIFT = 6,
  parameter int W_GEN = 5,
  parameter int W_MID = 6,
  parameter int W_SP  = 8,
  localparam int PFX_W = IMM_W - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic [IMM_W-1:0] preg,
  input  logic [PFX_W-1:0] field,
  input  wcls_t            wcls,
  output logic [IMM_W-1:0] imm
);
  localparam logic [IMM_W-1:0] M_GEN = IMM_W'((1 << W_GEN) - 1);
  localparam logic [IMM_W-1:0] M_MID = IMM_W'((1 << W_MID) - 1);
  localparam logic [IMM_W-1:0] M_SP  = IMM_W'((1 << W_SP) - 1);

  logic [IMM_W-1:0] fext;
  logic [IMM_W-1:0] mask;
  logic [IMM_W-1:0] upper;

  assign fext  = {{SHIFT{1'b0}}, field};
  assign upper = pend ? preg : '0;

  always_comb begin
    unique case (wcls)
      WC_GEN:  mask = M_GEN;
      WC_MID:  mask = M_MID;
      default: mask = M_SP;
    endcase
  end

  assign imm = upper | (fext & mask);

  AST_ZEXT_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && wcls == WC_GEN) |-> (imm[IMM_W-1:W_GEN] == '0)); // R2
  AST_ZEXT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && wcls == WC_SP) |-> (imm[IMM_W-1:W_SP] == '0)); // R2
  AST_PFX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ((imm & preg) == preg)); // R4
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic irq_req,
  output logic irq_allow,
  output logic irq_take
);
  assign irq_allow = !pend;
  assign irq_take  = irq_req && irq_allow;

  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !irq_take); // R8
  AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_req); // R8
endmodule

// File: rtl/pfx_imm_unit.sv
module pfx_imm_unit
  import pfxu_pkg::*;
#(
  parameter int IMM_W = 16,
  parameter int SHIFT = 6,
  parameter int W_GEN = 5,
  parameter int W_MID = 6,
  parameter int W_SP  = 8,
  localparam int PFX_W = IMM_W - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_pfx,
  input  logic [1:0]       in_wcls,
  input  logic [PFX_W-1:0] in_field,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IMM_W-1:0] out_imm,
  input  logic             irq_req,
  output logic             irq_allow,
  output logic             irq_take
);
  logic             pend;
  logic [IMM_W-1:0] preg;
  logic             acc;

  assign in_ready  = in_is_pfx || out_ready;
  assign out_valid = in_valid && !in_is_pfx;
  assign acc       = in_valid && in_ready;

  pfx_latch #(.IMM_W(IMM_W), .SHIFT(SHIFT)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (acc && in_is_pfx),
    .use_op   (acc && !in_is_pfx),
    .ld_field (in_field),
    .pend     (pend),
    .preg     (preg)
  );

  imm_merge #(
    .IMM_W(IMM_W), .SHIFT(SHIFT),
    .W_GEN(W_GEN), .W_MID(W_MID), .W_SP(W_SP)
  ) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .preg  (preg),
    .field (in_field),
    .wcls  (wcls_t'(in_wcls)),
    .imm   (out_imm)
  );

  irq_gate u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .irq_req   (irq_req),
    .irq_allow (irq_allow),
    .irq_take  (irq_take)
  );

  AST_PFX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_pfx) |-> (!out_valid && in_ready)); // R3
  AST_PLAIN_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_is_pfx) |-> (out_valid == in_valid && in_ready == out_ready)); // R9
  AST_RESET_OPEN: assert property (@(posedge clk)
    $rose(rst_n) |-> irq_allow); // R1
endmodule

// File: tb/sim_pfx_imm_unit.sv
`timescale 1ns/1ps
module sim_pfx_imm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_pfx = 1'b0;
  logic [1:0]  in_wcls = 2'd0;
  logic [9:0]  in_field = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_imm;
  logic        irq_req = 1'b0;
  logic        irq_allow;
  logic        irq_take;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic        m_pend = 1'b0;
  logic [15:0] m_preg = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pfx_imm_unit u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_pfx(in_is_pfx),
    .in_wcls(in_wcls), .in_field(in_field),
    .out_valid(out_valid), .out_ready(out_ready), .out_imm(out_imm),
    .irq_req(irq_req), .irq_allow(irq_allow), .irq_take(irq_take)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_imm(input logic [1:0] w, input logic [9:0] f);
    logic [15:0] m;
    m = (w == 2'd0) ? 16'h001F : (w == 2'd1) ? 16'h003F : 16'h00FF;
    return (m_pend ? m_preg : 16'h0) | ({6'b0, f} & m);
  endfunction

  // monitor: pops expected operands whenever an operand is handed over
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected operand", out_imm, 16'hxxxx);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, out_imm, e);
      end
    end
  end

  task automatic go(input bit v, input bit p, input logic [1:0] w, input logic [9:0] f,
                    input bit rdy, input bit fl, input bit irq, input string tag);
    bit hs;
    in_valid = v; in_is_pfx = p; in_wcls = w; in_field = f;
    out_ready = rdy; flush = fl; irq_req = irq;
    hs = v && (p || rdy);
    if (v && !p && rdy) begin
      exp_q.push_back(model_imm(w, f));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    chk("R8 irq_allow", {15'b0, irq_allow}, {15'b0, !m_pend});
    chk("R8 irq_take", {15'b0, irq_take}, {15'b0, irq && !m_pend});
    chk(p ? "R3 ready" : "R9 ready", {15'b0, in_ready}, {15'b0, p ? 1'b1 : rdy});
    chk(p ? "R3 out_valid" : "R9 out_valid", {15'b0, out_valid}, {15'b0, v && !p});
    @(posedge clk);
    if (fl) m_pend = 1'b0;
    else if (hs && p) begin m_pend = 1'b1; m_preg = {f, 6'b0}; end
    else if (hs) m_pend = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_allow after reset", {15'b0, irq_allow}, 16'd1);
    @(posedge clk); #1;
    // R1 / R2: plain operands, each width class
    go(1, 0, 2'd0, 10'h3FF, 1, 0, 1, "R1 R2 gen5");
    go(1, 0, 2'd1, 10'h3FF, 1, 0, 0, "R2 mid6");
    go(1, 0, 2'd2, 10'h3FF, 1, 0, 0, "R2 sp8");
    go(1, 0, 2'd3, 10'h155, 1, 0, 0, "R2 class3");
    // R4: 6 and 16 gives 400; R8 interrupt held while pending
    go(1, 1, 2'd0, 10'd6, 0, 0, 1, "R3 prefix");
    go(1, 0, 2'd1, 10'd16, 1, 0, 1, "R4 400");
    chk("R4 400 constant", model_imm(2'd1, 10'd16) | 16'h0, 16'd16);
    go(1, 0, 2'd0, 10'h00A, 1, 0, 1, "R6 cleared after use");
    // R5: run of prefixes, last one wins
    go(1, 1, 2'd0, 10'h3FF, 1, 0, 0, "R5 p1");
    go(1, 1, 2'd0, 10'h001, 1, 0, 0, "R5 p2");
    go(1, 0, 2'd0, 10'h01F, 1, 0, 0, "R5 last wins");
    // R4 overlap in 8-bit class
    go(1, 1, 2'd0, 10'h003, 1, 0, 0, "R4 p");
    go(1, 0, 2'd2, 10'h025, 1, 0, 0, "R4 sp8 overlap");
    // R6: stalled use keeps prefix
    go(1, 1, 2'd0, 10'h005, 1, 0, 0, "R6 p");
    go(1, 0, 2'd0, 10'h003, 0, 0, 1, "R6 stalled");
    go(1, 0, 2'd0, 10'h003, 1, 0, 0, "R6 after stall");
    // R7: flush alone, then flush together with a prefix
    go(1, 1, 2'd0, 10'h007, 1, 0, 0, "R7 p");
    go(0, 0, 2'd0, 10'h000, 1, 1, 1, "R7 flush");
    go(1, 0, 2'd0, 10'h001, 1, 0, 0, "R7 after flush");
    go(1, 1, 2'd0, 10'h009, 1, 1, 0, "R7 flush wins");
    go(1, 0, 2'd0, 10'h002, 1, 0, 0, "R7 no prefix");
    // R3: prefix accepted while consumer stalls
    go(1, 1, 2'd0, 10'h004, 0, 0, 0, "R3 p stalled");
    go(1, 0, 2'd1, 10'h021, 1, 0, 0, "R3 stalled prefix used");
    // R6: idle cycles keep prefix
    go(1, 1, 2'd0, 10'h008, 1, 0, 0, "R6 p");
    go(0, 0, 2'd0, 10'h000, 1, 0, 1, "R6 idle");
    go(0, 0, 2'd0, 10'h000, 0, 0, 1, "R6 idle");
    go(1, 0, 2'd0, 10'h000, 1, 0, 0, "R6 after idle");
    go(0, 0, 2'd0, 10'h000, 1, 0, 1, "R8 reopened");
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing operands actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule